// File: doc/BRIEF.md
# Fixed-Point Requantizer with Selectable Rounding

This block shortens a signed two's complement sample from a wider fixed-point format SN.L to a narrower format SN'.L', where L' is smaller than L and the integer width K' = N' - L' is equal to or smaller than K = N - L. It is placed between datapath stages that grow precision (multipliers, adder chains) and the stages that consume a shorter word.

The policy for the discarded fraction is picked on every sample by a two-bit mode input: plain truncation, round-half-up, or round-half-away-from-zero. After rounding, the value is tested against the output range. A run-time saturation enable picks between clamping an out-of-range result and passing its wrapped low bits through. An overflow flag is raised in both cases. There is one register stage on the output. A valid strobe travels alongside the data, and the register holds its contents on cycles with no valid input.

Top module: `rq_requant`

## Requirements
- R1: With mode 00 the output is the input shifted right arithmetically by L - L' bits, which is rounding toward minus infinity. The result is never larger than the input.
- R2: With mode 01 the output is the floor of the input plus half an output LSB. An input exactly midway between two output codes goes to the larger code, so -2.5 becomes -2 and 1.5 becomes 2.
- R3: With mode 10, an input that is not midway between two output codes goes to the nearest code. A midway input goes to the code farther from zero, so 2.5 becomes 3 and -2.5 becomes -3.
- R4: Mode 11 gives the same output and flag as mode 00 for every input.
- R5: out_ovf is 1 exactly when the rounded value lies outside [-2^(N'-1), 2^(N'-1)-1] in output LSB units. When K' = K, a negative input never sets it, and neither does mode 00 or 11.
- R6: With sat_en = 1 and overflow, the output is the largest positive code 0111...1 for a positive result and the most negative code 1000...0 for a negative result.
- R7: With sat_en = 0 and overflow, the output is the low N' bits of the rounded value (wraparound), and out_ovf is still 1.
- R8: out_valid equals in_valid one clock earlier. The out_data and out_ovf seen with out_valid = 1 belong to the sample presented on that earlier cycle.
- R9: On a cycle where in_valid is 0, out_data and out_ovf keep their previous values, whatever is on in_data, mode and sat_en.
- R10: While rst is high at a clock edge, out_valid, out_data and out_ovf become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_data as a sample to convert |
| in_data | input | IN_W | Input sample, signed, IN_FRAC fraction bits |
| mode | input | 2 | 00 truncate, 01 round half up, 10 round half away from zero, 11 same as 00 |
| sat_en | input | 1 | 1 clamps overflowed results, 0 wraps them |
| out_valid | output | 1 | Registered copy of in_valid |
| out_data | output | OUT_W | Requantized sample, signed, OUT_FRAC fraction bits |
| out_ovf | output | 1 | Rounded value did not fit the output range |

## Verification
On every cycle the assertions check the one-cycle valid alignment and the hold of the output register while input is idle. They also check that a saturated overflow lands on the extreme code whose sign matches the input, and that truncation and negative inputs never overflow when the integer width is kept. The exact rounded codes can only be shown by the bench's exhaustive sweep of every input code under every mode and both saturation settings, checked against an integer floor-division model. That model includes the midway ties of each policy, the positive overflow at the top of the range, and the wrapped values with saturation off.

// File: rtl/rq_pkg.sv
package rq_pkg;

    typedef enum logic [1:0] {
        RQ_TRUNC   = 2'b00,
        RQ_NEAREST = 2'b01,
        RQ_SYMM    = 2'b10,
        RQ_SPARE   = 2'b11
    } rq_mode_e;

    // Information about the bits being discarded
    typedef struct packed {
        logic sign;    // sign of the input sample
        logic guard;   // first discarded bit (half an output LSB)
        logic sticky;  // OR of every discarded bit below the guard
    } rq_tail_t;

    // Result of the range stage
    typedef struct packed {
        logic ovf;     // value outside output range
        logic neg;     // value negative
    } rq_range_t;

    // The spare encoding behaves as truncation
    function automatic rq_mode_e rq_effective(input logic [1:0] m);
        rq_mode_e r;
        case (m)
            2'b01:   r = RQ_NEAREST;
            2'b10:   r = RQ_SYMM;
            default: r = RQ_TRUNC;
        endcase
        return r;
    endfunction

    // One LSB increment decision for the kept bits
    function automatic logic rq_increment(input rq_mode_e m, input rq_tail_t t);
        logic inc;
        case (m)
            RQ_NEAREST: inc = t.guard;
            // tie (guard & !sticky): only positive values step up, negative
            // values stay at the floor, which is farther from zero
            RQ_SYMM:    inc = t.guard & (t.sticky | ~t.sign);
            default:    inc = 1'b0;
        endcase
        return inc;
    endfunction

endpackage

// File: rtl/rq_round.sv
module rq_round
    import rq_pkg::*;
#(
    parameter int IN_W     = 6,
    parameter int IN_FRAC  = 3,
    parameter int OUT_FRAC = 1,
    localparam int DROP    = IN_FRAC - OUT_FRAC,
    localparam int KW      = IN_W - DROP
) (
    input  logic [IN_W-1:0] in_data,
    input  logic [1:0]      mode,
    output logic [KW:0]     rounded
);

    logic [KW-1:0] kept;
    rq_tail_t      tail;
    rq_mode_e      eff;
    logic          inc;

    assign kept = in_data[IN_W-1:DROP];

    generate
        if (DROP > 1) begin : g_sticky
            assign tail.sticky = |in_data[DROP-2:0];
        end else begin : g_no_sticky
            assign tail.sticky = 1'b0;
        end
    endgenerate

    assign tail.sign  = in_data[IN_W-1];
    assign tail.guard = in_data[DROP-1];

    always_comb begin
        eff     = rq_effective(mode);
        inc     = rq_increment(eff, tail);
        rounded = {kept[KW-1], kept} + {{KW{1'b0}}, inc};
    end

endmodule

// File: rtl/rq_fit.sv
module rq_fit
    import rq_pkg::*;
#(
    parameter int SW    = 6,
    parameter int OUT_W = 4,
    localparam int HI_W = SW - OUT_W + 1
) (
    input  logic [SW-1:0]    value,
    input  logic             sat_en,
    output logic [OUT_W-1:0] data,
    output logic             ovf
);

    rq_range_t        rng;
    logic [HI_W-1:0]  hi;
    logic [OUT_W-1:0] pos_lim;
    logic [OUT_W-1:0] neg_lim;

    assign hi      = value[SW-1:OUT_W-1];
    assign pos_lim = {1'b0, {(OUT_W-1){1'b1}}};
    assign neg_lim = {1'b1, {(OUT_W-1){1'b0}}};

    always_comb begin
        // fits when every bit above the output sign copies it
        rng.ovf = ~((&hi) | (~|hi));
        rng.neg = value[SW-1];
        if (rng.ovf && sat_en) begin
            data = rng.neg ? neg_lim : pos_lim;
        end else begin
            data = value[OUT_W-1:0];
        end
        ovf = rng.ovf;
    end

endmodule

// File: rtl/rq_requant.sv
module rq_requant
    import rq_pkg::*;
#(
    parameter int IN_W     = 6,
    parameter int IN_FRAC  = 3,
    parameter int OUT_W    = 4,
    parameter int OUT_FRAC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic [1:0]       mode,
    input  logic             sat_en,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_ovf
);

    localparam int DROP = IN_FRAC - OUT_FRAC;
    localparam int KW   = IN_W - DROP;
    localparam int SW   = KW + 1;

    logic [SW-1:0]    rounded;
    logic [OUT_W-1:0] fit_data;
    logic             fit_ovf;

    rq_round #(
        .IN_W     (IN_W),
        .IN_FRAC  (IN_FRAC),
        .OUT_FRAC (OUT_FRAC)
    ) u_round (
        .in_data (in_data),
        .mode    (mode),
        .rounded (rounded)
    );

    rq_fit #(
        .SW    (SW),
        .OUT_W (OUT_W)
    ) u_fit (
        .value  (rounded),
        .sat_en (sat_en),
        .data   (fit_data),
        .ovf    (fit_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ovf   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= fit_data;
                out_ovf  <= fit_ovf;
            end
        end
    end

endmodule

// File: rtl/rq_requant_chk.sv
module rq_requant_chk #(
    parameter int IN_W     = 6,
    parameter int IN_FRAC  = 3,
    parameter int OUT_W    = 4,
    parameter int OUT_FRAC = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_data,
    input logic [1:0]       mode,
    input logic             sat_en,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             out_ovf
);

    localparam bit KEEP_INT = ((OUT_W - OUT_FRAC) == (IN_W - IN_FRAC));
    localparam logic [OUT_W-1:0] MAXC = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MINC = {1'b1, {(OUT_W-1){1'b0}}};

    // R8
    valid_align_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_ovf)));

    // R6
    sat_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_en && !in_data[IN_W-1]) |=> (!out_ovf || out_data == MAXC));

    // R6
    sat_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_en && in_data[IN_W-1]) |=> (!out_ovf || out_data == MINC));

    // R5
    neg_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && KEEP_INT && in_data[IN_W-1]) |=> !out_ovf);

    // R1 R4
    trunc_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && KEEP_INT && (mode[1] == mode[0])) |=> !out_ovf);

endmodule

bind rq_requant rq_requant_chk #(
    .IN_W     (IN_W),
    .IN_FRAC  (IN_FRAC),
    .OUT_W    (OUT_W),
    .OUT_FRAC (OUT_FRAC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .mode      (mode),
    .sat_en    (sat_en),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ovf   (out_ovf)
);

// File: tb/rq_requant_bench.sv
module rq_requant_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W     = 6;
    localparam int IN_FRAC  = 3;
    localparam int OUT_W    = 4;
    localparam int OUT_FRAC = 1;
    localparam int DROP  = IN_FRAC - OUT_FRAC;
    localparam int DIV   = 1 << DROP;
    localparam int NCODE = 1 << IN_W;
    localparam int OSPAN = 1 << OUT_W;
    localparam int MAXV  = (1 << (OUT_W - 1)) - 1;
    localparam int MINV  = -(1 << (OUT_W - 1));

    typedef struct {
        int    data;
        bit    ovf;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic [1:0]       mode = 2'b00;
    logic             sat_en = 1'b0;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;
    logic             out_ovf;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   running = 1'b0;
    bit   done = 1'b0;
    bit   have_last = 1'b0;
    int   last_data = 0;
    bit   last_ovf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rq_requant #(
        .IN_W     (IN_W),
        .IN_FRAC  (IN_FRAC),
        .OUT_W    (OUT_W),
        .OUT_FRAC (OUT_FRAC)
    ) u_rq_requant (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .mode      (mode),
        .sat_en    (sat_en),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ovf   (out_ovf)
    );

    function automatic exp_t model(input int code, input int m, input bit sat);
        exp_t e;
        int v, q, r, res;
        v = (code >= NCODE / 2) ? code - NCODE : code;
        r = ((v % DIV) + DIV) % DIV;
        q = (v - r) / DIV;
        case (m)
            1:       res = q + ((2 * r >= DIV) ? 1 : 0);
            2:       res = q + (((2 * r > DIV) || (2 * r == DIV && v >= 0)) ? 1 : 0);
            default: res = q;
        endcase
        e.tag = (m == 0) ? "R1" : (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
        e.ovf = (res > MAXV) || (res < MINV);
        if (e.ovf && sat) begin
            e.data = (res > MAXV) ? MAXV + OSPAN : MINV + OSPAN;
            e.data = e.data % OSPAN;
            e.tag  = {e.tag, "/R5/R6"};
        end else begin
            e.data = ((res % OSPAN) + OSPAN) % OSPAN;
            if (e.ovf) e.tag = {e.tag, "/R5/R7"};
        end
        return e;
    endfunction

    task automatic drive(input int code, input int m, input bit sat);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = code[IN_W-1:0];
        mode     = m[1:0];
        sat_en   = sat;
        exp_q.push_back(model(code, m, sat));
    endtask

    task automatic idle(input int junk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = junk[IN_W-1:0];
        mode     = junk[1:0];
        sat_en   = ~sat_en;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (running && !rst) begin
            if (out_valid) begin
                n_vec++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R8: out_valid=1 with no sample pending, expected out_valid=0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (int'(out_data) != e.data || out_ovf != e.ovf) begin
                        n_bad++;
                        $display("FAIL %s: data=%0d ovf=%0b, expected data=%0d ovf=%0b",
                                 e.tag, out_data, out_ovf, e.data, e.ovf);
                    end
                end
                have_last = 1'b1;
                last_data = int'(out_data);
                last_ovf  = out_ovf;
            end else if (have_last) begin
                n_vec++;
                if (int'(out_data) != last_data || out_ovf != last_ovf) begin
                    n_bad++;
                    $display("FAIL R9: idle data=%0d ovf=%0b, expected data=%0d ovf=%0b",
                             out_data, out_ovf, last_data, last_ovf);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        n_vec++;
        if (out_valid !== 1'b0 || out_data !== '0 || out_ovf !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: valid=%0b data=%0d ovf=%0b, expected 0 0 0",
                     out_valid, out_data, out_ovf);
        end
        rst = 1'b0;
        running = 1'b1;
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int c = 0; c < NCODE; c++) begin
                    drive(c, m, s[0]);
                    if (c % 16 == 15) idle(c * 7 + m);
                end
            end
        end
        idle(5);
        idle(42);
        idle(17);
        // R8: every pushed sample has been returned
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R8: %0d samples never returned, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule